// File: doc/BRIEF.md
# Eight-Bit Timer/Counter with Selectable Prescaler

This block is an 8-bit up-counter for a small processor. It advances on one of two event sources. The first is an internal tick that fires on every second system clock. The second is a chosen edge of an asynchronous input pin, which is brought into the clock domain by a two-flop synchronizer. An optional power-of-two prescaler can be placed between the event source and the counter. When the count wraps from its maximum value to zero, the block emits a one-cycle overflow pulse toward an interrupt controller.

The processor loads the counter through a write strobe and a data bus, and reads it through `count_o`. A load also empties the prescaler and swallows the next two advance opportunities, so that software sees a predictable restart. The configuration inputs (source, edge polarity, prescaler assignment and rate) come from an option register outside this block.

Top module: `tmr8_unit`

## Requirements
- R1: After reset, `count_o` is 0x00 and `ovf_o` is 0.
- R2: When `wr_en_i` is high at a clock edge, `count_o` shows `wr_data_i` after that edge. A load wins over an advance that falls in the same cycle.
- R3: With `src_ext_i`=0 and `psc_en_i`=0, the internal tick fires on every second clock, and each tick is one advance opportunity for the counter.
- R4: With `psc_en_i`=1, a `psc_rate_i` value of n passes one advance to the counter for every 2^(n+1) source events. So 0 gives 1:2 and 7 gives 1:256.
- R5: With `psc_en_i`=0, the counter advances on every source event, whatever the value of `psc_rate_i`.
- R6: With `src_ext_i`=1 and `edge_fall_i`=0, each rising edge of `ext_clk_i` is an event. After the pin rises, the count changes on the third clock edge. Falling edges are ignored.
- R7: With `src_ext_i`=1 and `edge_fall_i`=1, each falling edge of `ext_clk_i` is an event, with the same three-edge latency. Rising edges are ignored.
- R8: A load clears the prescaler and restarts the internal tick phase. The first two advance opportunities after a load do not change the count. In timer mode without prescaler, the first increment therefore lands six clocks after the load edge. With a divide ratio N, it lands 6·N clocks after the load edge.
- R9: An advance from 0xFF gives 0x00 and raises `ovf_o` for exactly one cycle, the cycle in which `count_o` first reads 0x00.
- R10: The prescaler also applies to external events when `psc_en_i`=1 and `src_ext_i`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ext_clk_i | input | 1 | Asynchronous external event pin |
| src_ext_i | input | 1 | 1: count pin edges; 0: count internal ticks |
| edge_fall_i | input | 1 | 1: falling pin edges; 0: rising pin edges |
| psc_en_i | input | 1 | 1: prescaler placed in front of the counter |
| psc_rate_i | input | 3 | Prescale exponent n, ratio 2^(n+1) |
| wr_en_i | input | 1 | Counter load strobe |
| wr_data_i | input | 8 | Counter load value |
| count_o | output | 8 | Current counter value |
| ovf_o | output | 1 | One-cycle wrap pulse |

## Verification
The assertions assume three things about the inputs. First, `src_ext_i` is stable across any pair of cycles they compare. Second, the pin has been through the synchronizer, so its derived edges can never come on adjacent cycles. Third, the prescaler stays assigned for the cycle after a load when the clear is checked. The bench changes configuration only while the pin is idle, and before a load, never during a timed window. It holds each pin level for four clocks, which is longer than the synchronizer depth, so every edge is seen exactly once.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  localparam int CNT_W   = 8;
  localparam int PSC_W   = 8;
  localparam int RATE_W  = 3;
  localparam int SYNC_N  = 2;
  localparam int INH_N   = 2;

  typedef enum logic {SRC_TICK = 1'b0, SRC_PIN = 1'b1} src_e;
endpackage

// File: rtl/tmr8_event_src.sv
module tmr8_event_src
  import tmr8_pkg::*;
#(
  parameter int SYNC_STAGES = SYNC_N
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic src_ext_i,
  input  logic edge_fall_i,
  input  logic phase_clr_i,
  output logic tick_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   phase_q;
  logic                   pin_edge;
  src_e                   src;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[g] <= 1'b0;
        else if (g == 0) sync_q[g] <= pin_i;
        else sync_q[g] <= sync_q[(g > 0) ? g-1 : 0];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      phase_q <= 1'b0;
    end else begin
      prev_q  <= sync_q[SYNC_STAGES-1];
      phase_q <= phase_clr_i ? 1'b0 : ~phase_q;
    end
  end

  assign src = src_e'(src_ext_i);

  always_comb begin
    if (edge_fall_i) pin_edge = prev_q & ~sync_q[SYNC_STAGES-1];
    else             pin_edge = ~prev_q & sync_q[SYNC_STAGES-1];
  end

  assign tick_o = (src == SRC_PIN) ? pin_edge : phase_q;

  // R3/R6: events never arrive on adjacent cycles in a fixed mode
  a_r3_tick_spaced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o ##1 $stable(src_ext_i) |-> !tick_o);
endmodule

// File: rtl/tmr8_prescaler.sv
module tmr8_prescaler
  import tmr8_pkg::*;
#(
  parameter int DIV_W  = PSC_W,
  parameter int RATE_B = RATE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              en_i,
  input  logic              clr_i,
  input  logic [RATE_B-1:0] rate_i,
  output logic              inc_o
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  always_comb begin
    for (int i = 0; i < DIV_W; i++) mask[i] = (i <= int'(rate_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             div_q <= '0;
    else if (clr_i || !en_i) div_q <= '0;
    else if (tick_i)         div_q <= div_q + 1'b1;
  end

  assign inc_o = en_i ? (tick_i & (&(div_q | ~mask))) : tick_i;

  // R8: a cleared prescaler cannot release an advance on the next cycle
  a_r8_clr_no_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && clr_i) ##1 en_i |-> !inc_o);
endmodule

// File: rtl/tmr8_counter.sv
module tmr8_counter
  import tmr8_pkg::*;
#(
  parameter int WIDTH   = CNT_W,
  parameter int INHIBIT = INH_N
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic [WIDTH-1:0] cnt_o,
  output logic             ovf_o
);
  localparam int INH_W = $clog2(INHIBIT + 1);

  logic [WIDTH-1:0] cnt_q;
  logic [INH_W-1:0] inh_q;
  logic             ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      inh_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= 1'b0;
      if (wr_en_i) begin
        cnt_q <= wr_data_i;
        inh_q <= INH_W'(INHIBIT);
      end else if (inc_i) begin
        if (inh_q != '0) inh_q <= inh_q - 1'b1;
        else begin
          cnt_q <= cnt_q + 1'b1;
          ovf_q <= &cnt_q;
        end
      end
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

  a_r2_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> cnt_q == $past(wr_data_i));
  a_r8_hold_after_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i ##1 !wr_en_i |=> cnt_q == $past(cnt_q));
  a_r9_ovf_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |=> !ovf_q);
  a_r9_ovf_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |-> cnt_q == '0);
  a_r3_step_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> (cnt_q == $past(cnt_q) || cnt_q == WIDTH'($past(cnt_q) + 1'b1)));
endmodule

// File: rtl/tmr8_unit.sv
module tmr8_unit
  import tmr8_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_clk_i,
  input  logic              src_ext_i,
  input  logic              edge_fall_i,
  input  logic              psc_en_i,
  input  logic [RATE_W-1:0] psc_rate_i,
  input  logic              wr_en_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              ovf_o
);
  logic tick;
  logic inc;

  tmr8_event_src #(.SYNC_STAGES(SYNC_N)) u_src (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pin_i       (ext_clk_i),
    .src_ext_i   (src_ext_i),
    .edge_fall_i (edge_fall_i),
    .phase_clr_i (wr_en_i),
    .tick_o      (tick)
  );

  tmr8_prescaler #(.DIV_W(PSC_W), .RATE_B(RATE_W)) u_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .en_i   (psc_en_i),
    .clr_i  (wr_en_i),
    .rate_i (psc_rate_i),
    .inc_o  (inc)
  );

  tmr8_counter #(.WIDTH(CNT_W), .INHIBIT(INH_N)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .inc_i     (inc),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .cnt_o     (count_o),
    .ovf_o     (ovf_o)
  );
endmodule

// File: tb/sim_tmr8_unit.sv
module sim_tmr8_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin = 1'b0;
  logic       src_ext = 1'b0;
  logic       fall = 1'b0;
  logic       psc_en = 1'b0;
  logic [2:0] rate = 3'd0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] count;
  logic       ovf;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tmr8_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .ext_clk_i(pin), .src_ext_i(src_ext),
    .edge_fall_i(fall), .psc_en_i(psc_en), .psc_rate_i(rate),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .count_o(count), .ovf_o(ovf)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic skip(input int n);
    repeat (n) @(negedge clk);
  endtask

  // leaves the bench at the sample point just after the load edge (k=0)
  task automatic load(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      pin = 1'b1; skip(4);
      pin = 1'b0; skip(4);
    end
  endtask

  task automatic t_reset;
    chk("R1 count", count, 8'h00);
    chk("R1 ovf", {7'd0, ovf}, 8'h00);
  endtask

  task automatic t_timer_plain;
    src_ext = 1'b0; psc_en = 1'b0;
    load(8'h10);
    chk("R2 load", count, 8'h10);
    skip(5); chk("R8 inhibit k5", count, 8'h10);
    skip(1); chk("R3 k6", count, 8'h11);
    skip(1); chk("R3 k7", count, 8'h11);
    skip(1); chk("R3 k8", count, 8'h12);
    skip(2); chk("R3 k10", count, 8'h13);
  endtask

  task automatic t_bypass;
    psc_en = 1'b0; rate = 3'd5;
    load(8'h33);
    skip(5); chk("R5 k5", count, 8'h33);
    skip(1); chk("R5 k6", count, 8'h34);
    skip(2); chk("R5 k8", count, 8'h35);
  endtask

  task automatic t_prescale;
    psc_en = 1'b1; rate = 3'd1;
    load(8'h20);
    skip(23); chk("R4 div4 k23", count, 8'h20);
    skip(1);  chk("R4 div4 k24", count, 8'h21);
    skip(7);  chk("R4 div4 k31", count, 8'h21);
    skip(1);  chk("R4 div4 k32", count, 8'h22);
    // reload mid-cycle must restart the prescaler
    load(8'h50); skip(10);
    load(8'h60);
    skip(23); chk("R8 psc clr k23", count, 8'h60);
    skip(1);  chk("R8 psc clr k24", count, 8'h61);
    rate = 3'd7;
    load(8'h70);
    skip(1535); chk("R4 div256 k1535", count, 8'h70);
    skip(1);    chk("R4 div256 k1536", count, 8'h71);
    psc_en = 1'b0;
  endtask

  task automatic t_overflow;
    src_ext = 1'b0; psc_en = 1'b0;
    load(8'hFE);
    skip(6); chk("R9 k6", count, 8'hFF);
    skip(1); chk("R9 ovf low k7", {7'd0, ovf}, 8'h00);
    skip(1); chk("R9 wrap k8", count, 8'h00);
    chk("R9 ovf k8", {7'd0, ovf}, 8'h01);
    skip(1); chk("R9 ovf drop k9", {7'd0, ovf}, 8'h00);
    skip(1); chk("R9 k10", count, 8'h01);
  endtask

  task automatic t_ext_rise;
    src_ext = 1'b1; fall = 1'b0; psc_en = 1'b0; pin = 1'b0;
    skip(4);
    load(8'h40);
    pulse(5);
    chk("R6 rising x5", count, 8'h43);
    pin = 1'b1;
    skip(2); chk("R6 latency 2", count, 8'h43);
    skip(1); chk("R6 latency 3", count, 8'h44);
    skip(3); pin = 1'b0;
    skip(5); chk("R6 fall ignored", count, 8'h44);
  endtask

  task automatic t_ext_fall;
    src_ext = 1'b1; fall = 1'b1; psc_en = 1'b0; pin = 1'b0;
    skip(4);
    load(8'h80);
    pulse(4);
    chk("R7 falling x4", count, 8'h82);
    pin = 1'b1; skip(5);
    chk("R7 rise ignored", count, 8'h82);
    pin = 1'b0;
    skip(2); chk("R7 latency 2", count, 8'h82);
    skip(1); chk("R7 latency 3", count, 8'h83);
    fall = 1'b0; skip(4);
  endtask

  task automatic t_ext_psc;
    src_ext = 1'b1; fall = 1'b0; psc_en = 1'b1; rate = 3'd0; pin = 1'b0;
    skip(4);
    load(8'h00);
    pulse(6);
    chk("R10 six edges", count, 8'h01);
    pulse(2);
    chk("R10 eight edges", count, 8'h02);
    pulse(1);
    chk("R10 odd edge held", count, 8'h02);
    psc_en = 1'b0; src_ext = 1'b0;
  endtask

  initial begin
    fork
      begin
        skip(3);
        rst_n = 1'b1;
        skip(1);
        t_reset();
        t_timer_plain();
        t_bypass();
        t_prescale();
        t_overflow();
        t_ext_rise();
        t_ext_fall();
        t_ext_psc();
        done = 1'b1;
      end
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          n_chk++; n_bad++;
          $display("FAIL watchdog: actual timeout expected completion");
        end
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule